// File: doc/BRIEF.md
# Multi-Mode Banked RAM Controller

This block sits on a processor bus and serves memory cycles out of one of several equally sized banks of byte storage. A single bank register picks which bank answers. Software changes the bank by writing a byte to an output port. The port address, the number of banks and the meaning of the written byte depend on which of five select schemes is chosen on a configuration input. Two of the schemes take a binary bank number with a range check. The other schemes take a one-hot byte, and one of these accepts two alias codes.

Memory is split into pages. Only pages marked in a page-enable mask answer memory cycles, so the controller can share the address space with other memory. The mask is set up with page ranges: a first page, a last page, and whether to enable or disable them. Storage is modelled behaviourally as inferable block RAM, addressed by the bank number concatenated above the bus address. Read data comes back one clock after the request. A cold (power-on) reset and an ordinary reset are separate inputs, because the first ordinary reset after power-on keeps the bank while every later one clears it.

Defaults are sized small for elaboration (256-byte banks of four 64-byte pages). A full-size build sets `ADDR_W=16` and `PAGE_W=8`.

Top module: `banked_ram_ctrl`

## Requirements
- R1: `mode_sel` codes map to select schemes. 0 means off. 1 means binary select on port 0xFF with 8 banks. 2 means one-hot select on port 0x40 with 8 banks. 3 means one-hot select on port 0x40 with 7 banks. 4 means binary select on port 0xC0 with 16 banks. 5 means binary select on port 0x40 with 16 banks. Codes 6 and 7 behave as off. An I/O write to any port other than the scheme's own port leaves the bank unchanged, and in off mode every write is ignored.
- R2: In codes 1, 4 and 5 the written byte is the bank number. It is accepted only if it is below the scheme's bank count. Otherwise the bank is unchanged.
- R3: In code 2 the byte 0x01<<n selects bank n, for n from 0 to 7. The byte 0x41 selects bank 0 and 0x42 selects bank 1. Every other byte is ignored.
- R4: In code 3 bit 7 of the byte is cleared first. The result 0x01<<n then selects bank n, for n from 0 to 6. Every other result is ignored, so 0x81 selects bank 0 and 0x80 is ignored.
- R5: A memory cycle reaches the storage byte at bank × 2^ADDR_W + `mem_addr`. Data written in one bank is never seen in another bank.
- R6: A page range write sets (`pg_cfg_set`=1) or clears the mask bits of pages `pg_cfg_first` through `pg_cfg_last`. The page of an address is `mem_addr[ADDR_W-1:PAGE_W]`. A cycle to a disabled page gives `mem_hit`=0 and `mem_rdata`=0xFF, and a write to it leaves the storage unchanged.
- R7: `mem_hit` and `mem_rdata` answer a request one clock after it is presented, and `mem_rdata` is 0xFF for a write. A memory request in the cycle right after a bank-select write already uses the new bank.
- R8: `cold_rst` sets the bank to 0, clears the page mask and arms a power-on flag. The first `rst` after that keeps the bank and disarms the flag. Each later `rst` sets the bank to 0.
- R9: A change of `mode_sel` sets the bank to 0. Off mode maps no memory: `mem_hit`=0 and `mem_rdata`=0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Ordinary reset, synchronous, active high |
| mode_sel | input | 3 | Select scheme code |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| pg_cfg_we | input | 1 | Apply a page range to the mask |
| pg_cfg_set | input | 1 | 1 enables the range, 0 disables it |
| pg_cfg_first | input | ADDR_W-PAGE_W | First page of the range |
| pg_cfg_last | input | ADDR_W-PAGE_W | Last page of the range |
| mem_req | input | 1 | Memory cycle request |
| mem_we | input | 1 | 1 for a memory write |
| mem_addr | input | ADDR_W | Bus memory address |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Read data, 0xFF when not served |
| mem_hit | output | 1 | The previous request was served |

## Verification
The bench writes a distinct marker to offset 0 of every bank, then works out the active bank by reading it back. This catches a decoder that maps a one-hot code to the wrong bank, or that drops the 0x41/0x42 aliases. It also catches a decoder that leaves bit 7 unmasked in the 7-bank scheme, or that accepts the count value itself instead of stopping one below it. Writes to the other schemes' ports and rejected codes are followed by a readback. If such a write leaked into the register, the marker would change. The reset sequence tells a controller that clears the bank on the first ordinary reset apart from one that never clears it. The page tests write through a disabled page and read back later. A controller that filtered only reads would return the wrong byte.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_BIN8_FF  = 3'd1,
    MODE_HOT8     = 3'd2,
    MODE_HOT7     = 3'd3,
    MODE_BIN16_C0 = 3'd4,
    MODE_BIN16_40 = 3'd5
  } sel_mode_t;

  // Port that a scheme listens on
  function automatic logic [7:0] mode_port(sel_mode_t m);
    case (m)
      MODE_BIN8_FF:                       return 8'hFF;
      MODE_BIN16_C0:                      return 8'hC0;
      MODE_HOT8, MODE_HOT7, MODE_BIN16_40: return 8'h40;
      default:                            return 8'h00;
    endcase
  endfunction

  // Number of banks a scheme can reach (0: scheme off)
  function automatic logic [4:0] mode_banks(sel_mode_t m);
    case (m)
      MODE_BIN8_FF, MODE_HOT8:        return 5'd8;
      MODE_HOT7:                      return 5'd7;
      MODE_BIN16_C0, MODE_BIN16_40:   return 5'd16;
      default:                        return 5'd0;
    endcase
  endfunction

  function automatic logic mode_is_binary(sel_mode_t m);
    return (m == MODE_BIN8_FF) || (m == MODE_BIN16_C0) || (m == MODE_BIN16_40);
  endfunction

endpackage

// File: rtl/bank_sel_decode.sv
module bank_sel_decode
  import banked_ram_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  sel_mode_t         mode,
  input  logic              io_wr,
  input  logic [7:0]        io_port,
  input  logic [7:0]        io_wdata,
  output logic              sel_ok,
  output logic [BANK_W-1:0] sel_bank
);

  localparam int HOT_N = 8;

  logic [4:0]       cnt;
  logic             port_hit;
  logic [7:0]       hot_byte;
  logic [HOT_N-1:0] hot_hit;
  logic [2:0]       hot_idx;

  assign cnt      = mode_banks(mode);
  assign port_hit = io_wr && (cnt != 5'd0) && (io_port == mode_port(mode));

  // Normalise the byte: strip bit 7 for the 7-bank scheme, fold aliases
  always_comb begin
    hot_byte = io_wdata;
    if (mode == MODE_HOT7)
      hot_byte[7] = 1'b0;
    else if (mode == MODE_HOT8 && io_wdata == 8'h41)
      hot_byte = 8'h01;
    else if (mode == MODE_HOT8 && io_wdata == 8'h42)
      hot_byte = 8'h02;
  end

  for (genvar g = 0; g < HOT_N; g++) begin : g_hot
    assign hot_hit[g] = (hot_byte == (8'h01 << g));
  end

  always_comb begin
    hot_idx = 3'd0;
    for (int i = 0; i < HOT_N; i++)
      if (hot_hit[i]) hot_idx = 3'(i);
  end

  assign sel_ok   = port_hit && (mode_is_binary(mode) ? ({3'b000, cnt} > io_wdata)
                                                      : (|hot_hit));
  assign sel_bank = mode_is_binary(mode) ? io_wdata[BANK_W-1:0] : BANK_W'(hot_idx);

  // R2 R3 R4: an accepted code never names a bank beyond the scheme's count
  always_comb begin
    if (sel_ok)
      assert_sel_below_count_R2: assert (8'(sel_bank) < {3'b000, cnt})
        else $error("accepted bank beyond scheme count");
  end

endmodule

// File: rtl/page_mask.sv
module page_mask #(
  parameter int PG_W = 2
) (
  input  logic            clk,
  input  logic            cold_rst,
  input  logic            cfg_we,
  input  logic            cfg_set,
  input  logic [PG_W-1:0] cfg_first,
  input  logic [PG_W-1:0] cfg_last,
  input  logic [PG_W-1:0] look_pg,
  output logic            look_en
);

  localparam int PG_N = 1 << PG_W;

  logic [PG_N-1:0] mask_q;
  logic [PG_N-1:0] in_rng;

  for (genvar p = 0; p < PG_N; p++) begin : g_rng
    assign in_rng[p] = (PG_W'(p) >= cfg_first) && (PG_W'(p) <= cfg_last);
  end

  always_ff @(posedge clk) begin
    if (cold_rst)
      mask_q <= '0;
    else if (cfg_we)
      mask_q <= (mask_q & ~in_rng) | (cfg_set ? in_rng : '0);
  end

  assign look_en = mask_q[look_pg];

  // R6: a range that starts at page 0 leaves page 0 in the requested state
  assert_range_applies_R6: assert property (@(posedge clk) disable iff (cold_rst)
    (!$past(cold_rst) && $past(cfg_we) && $past(cfg_first) == '0)
      |-> (mask_q[0] == $past(cfg_set)));

  // R6: without a range write the mask holds
  assert_mask_holds_R6: assert property (@(posedge clk) disable iff (cold_rst)
    (!$past(cold_rst) && !$past(cfg_we)) |-> $stable(mask_q));

endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/banked_ram_ctrl.sv
module banked_ram_ctrl
  import banked_ram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 6,
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     cold_rst,
  input  logic                     rst,
  input  logic [2:0]               mode_sel,
  input  logic                     io_wr,
  input  logic [7:0]               io_port,
  input  logic [7:0]               io_wdata,
  input  logic                     pg_cfg_we,
  input  logic                     pg_cfg_set,
  input  logic [ADDR_W-PAGE_W-1:0] pg_cfg_first,
  input  logic [ADDR_W-PAGE_W-1:0] pg_cfg_last,
  input  logic                     mem_req,
  input  logic                     mem_we,
  input  logic [ADDR_W-1:0]        mem_addr,
  input  logic [7:0]               mem_wdata,
  output logic [7:0]               mem_rdata,
  output logic                     mem_hit
);

  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int STORE_W = BANK_W + ADDR_W;

  sel_mode_t         mode_q;
  sel_mode_t         mode_in;
  logic [BANK_W-1:0] bank_q;
  logic              poc_q;
  logic              mode_chg;
  logic              sel_ok;
  logic [BANK_W-1:0] sel_bank;
  logic              pg_en;
  logic              map_on;
  logic              hit;
  logic              hit_q;
  logic              rd_q;
  logic [7:0]        ram_q;

  assign mode_in  = sel_mode_t'(mode_sel);
  assign mode_chg = (mode_in != mode_q);
  assign map_on   = (mode_banks(mode_q) != 5'd0);

  bank_sel_decode #(.BANK_W(BANK_W)) u_decode (
    .mode     (mode_q),
    .io_wr    (io_wr),
    .io_port  (io_port),
    .io_wdata (io_wdata),
    .sel_ok   (sel_ok),
    .sel_bank (sel_bank)
  );

  page_mask #(.PG_W(PG_W)) u_mask (
    .clk       (clk),
    .cold_rst  (cold_rst),
    .cfg_we    (pg_cfg_we),
    .cfg_set   (pg_cfg_set),
    .cfg_first (pg_cfg_first),
    .cfg_last  (pg_cfg_last),
    .look_pg   (mem_addr[ADDR_W-1:PAGE_W]),
    .look_en   (pg_en)
  );

  // Bank register: cold reset > scheme change > ordinary reset > port write
  always_ff @(posedge clk) begin
    if (cold_rst) begin
      mode_q <= mode_in;
      bank_q <= '0;
      poc_q  <= 1'b1;
    end else begin
      mode_q <= mode_in;
      if (mode_chg)
        bank_q <= '0;
      else if (rst) begin
        if (!poc_q) bank_q <= '0;
      end else if (sel_ok)
        bank_q <= sel_bank;
      if (rst) poc_q <= 1'b0;
    end
  end

  assign hit = mem_req && map_on && pg_en;

  bank_store #(.AW(STORE_W), .DW(8)) u_store (
    .clk   (clk),
    .we    (hit && mem_we),
    .addr  ({bank_q, mem_addr}),
    .wdata (mem_wdata),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      hit_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      hit_q <= hit;
      rd_q  <= hit && !mem_we;
    end
  end

  assign mem_hit   = hit_q;
  assign mem_rdata = rd_q ? ram_q : 8'hFF;

  // R2: the bank never leaves the range of the active scheme
  assert_bank_in_range_R2: assert property (@(posedge clk) disable iff (cold_rst)
    (mode_banks(mode_q) == 5'd0) ? (bank_q == '0) : (5'(bank_q) < mode_banks(mode_q)));

  // R9: a scheme change lands on bank 0
  assert_mode_change_bank0_R9: assert property (@(posedge clk) disable iff (cold_rst)
    (!$past(cold_rst) && $past(mode_chg)) |-> (bank_q == '0));

  // R9: no memory is served in off mode
  assert_off_no_hit_R9: assert property (@(posedge clk) disable iff (cold_rst)
    (!$past(cold_rst) && $past(mem_req) && !$past(map_on)) |-> (!mem_hit && mem_rdata == 8'hFF));

  // R6: a disabled page is never served
  assert_disabled_page_R6: assert property (@(posedge clk) disable iff (cold_rst)
    (!$past(cold_rst) && $past(mem_req) && !$past(pg_en)) |-> !mem_hit);

  // R8: first ordinary reset after power-on keeps the bank
  assert_first_reset_keeps_R8: assert property (@(posedge clk) disable iff (cold_rst)
    (!$past(cold_rst) && $past(rst) && $past(poc_q) && !$past(mode_chg))
      |-> (bank_q == $past(bank_q) && !poc_q));

  // R8: later ordinary resets clear the bank
  assert_warm_reset_clears_R8: assert property (@(posedge clk) disable iff (cold_rst)
    (!$past(cold_rst) && $past(rst) && !$past(poc_q)) |-> (bank_q == '0));

endmodule

// File: tb/test_banked_ram_ctrl.sv
module test_banked_ram_ctrl;

  localparam int ADDR_W = 8;
  localparam int PAGE_W = 6;
  localparam int PG_W   = ADDR_W - PAGE_W;

  logic              clk = 1'b0;
  logic              cold_rst = 1'b1;
  logic              rst = 1'b0;
  logic [2:0]        mode_sel = 3'd4;
  logic              io_wr = 1'b0;
  logic [7:0]        io_port = 8'h00;
  logic [7:0]        io_wdata = 8'h00;
  logic              pg_cfg_we = 1'b0;
  logic              pg_cfg_set = 1'b0;
  logic [PG_W-1:0]   pg_cfg_first = '0;
  logic [PG_W-1:0]   pg_cfg_last = '0;
  logic              mem_req = 1'b0;
  logic              mem_we = 1'b0;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic [7:0]        mem_wdata = 8'h00;
  logic [7:0]        mem_rdata;
  logic              mem_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  banked_ram_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK_W(4)) i_banked_ram_ctrl (
    .clk(clk), .cold_rst(cold_rst), .rst(rst), .mode_sel(mode_sel),
    .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
    .pg_cfg_we(pg_cfg_we), .pg_cfg_set(pg_cfg_set),
    .pg_cfg_first(pg_cfg_first), .pg_cfg_last(pg_cfg_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_hit(mem_hit)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cold();
    @(negedge clk) cold_rst = 1'b1;
    @(negedge clk);
    @(negedge clk) cold_rst = 1'b0;
  endtask

  task automatic do_rst();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic set_mode(int m);
    @(negedge clk) mode_sel = 3'(m);
    @(negedge clk);
  endtask

  task automatic io_write(logic [7:0] port, logic [7:0] data);
    @(negedge clk) begin io_wr = 1'b1; io_port = port; io_wdata = data; end
    @(negedge clk) io_wr = 1'b0;
  endtask

  task automatic pages(bit set, int first, int last);
    @(negedge clk) begin
      pg_cfg_we = 1'b1; pg_cfg_set = set;
      pg_cfg_first = PG_W'(first); pg_cfg_last = PG_W'(last);
    end
    @(negedge clk) pg_cfg_we = 1'b0;
  endtask

  task automatic mem_write(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk) begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d; end
    @(negedge clk) begin mem_req = 1'b0; mem_we = 1'b0; end
  endtask

  task automatic mem_read(logic [ADDR_W-1:0] a, output logic [7:0] d, output logic h);
    @(negedge clk) begin mem_req = 1'b1; mem_we = 1'b0; mem_addr = a; end
    @(negedge clk) begin d = mem_rdata; h = mem_hit; mem_req = 1'b0; end
  endtask

  function automatic logic [7:0] marker(int b);
    return 8'hA0 | 8'(b);
  endfunction

  // Active bank is recognised by the marker at offset 0
  task automatic bank_is(string req, int exp);
    logic [7:0] d; logic h;
    mem_read('0, d, h);
    chk(req, "bank marker hit", int'(h), 1);
    chk(req, "bank marker", int'(d), int'(marker(exp)));
  endtask

  task automatic miss_at(string req, logic [ADDR_W-1:0] a);
    logic [7:0] d; logic h;
    mem_read(a, d, h);
    chk(req, "miss hit flag", int'(h), 0);
    chk(req, "miss data", int'(d), 8'hFF);
  endtask

  task automatic t_reset_state();
    chk("R8", "hit after cold reset", int'(mem_hit), 0);
    chk("R8", "rdata after cold reset", int'(mem_rdata), 8'hFF);
    miss_at("R8", 8'h00);   // mask cleared by cold reset
  endtask

  task automatic t_fill_markers();
    pages(1'b1, 0, 3);
    for (int b = 0; b < 16; b++) begin
      io_write(8'hC0, 8'(b));
      mem_write('0, marker(b));
    end
    for (int b = 0; b < 16; b++) begin
      io_write(8'hC0, 8'(b));
      bank_is("R2", b);
    end
  endtask

  task automatic t_isolation();
    logic [7:0] d; logic h;
    io_write(8'hC0, 8'd3); mem_write(8'h37, 8'h5A);
    io_write(8'hC0, 8'd4); mem_write(8'h37, 8'hC3);
    io_write(8'hC0, 8'd3); mem_read(8'h37, d, h);
    chk("R5", "bank 3 byte", int'(d), 8'h5A);
    io_write(8'hC0, 8'd4); mem_read(8'h37, d, h);
    chk("R5", "bank 4 byte", int'(d), 8'hC3);
    chk("R5", "bank 4 hit", int'(h), 1);
  endtask

  task automatic t_select_latency();
    logic [7:0] d;
    io_write(8'hC0, 8'd2);
    @(negedge clk) begin io_wr = 1'b1; io_port = 8'hC0; io_wdata = 8'd6; end
    @(negedge clk) begin io_wr = 1'b0; mem_req = 1'b1; mem_we = 1'b0; mem_addr = '0; end
    @(negedge clk) begin d = mem_rdata; mem_req = 1'b0; end
    chk("R7", "read right after select", int'(d), int'(marker(6)));
    mem_write(8'h01, 8'h77);
    chk("R7", "rdata on write cycle", int'(mem_rdata), 8'hFF);
  endtask

  task automatic t_mode_bin16_c0();
    io_write(8'hC0, 8'd9);
    io_write(8'hC0, 8'd16);  bank_is("R2", 9);
    io_write(8'hC0, 8'hFF);  bank_is("R2", 9);
    io_write(8'h40, 8'd3);   bank_is("R1", 9);
  endtask

  task automatic t_mode_bin8_ff();
    io_write(8'hC0, 8'd5);
    set_mode(1);             bank_is("R9", 0);
    io_write(8'hFF, 8'd7);   bank_is("R2", 7);
    io_write(8'hFF, 8'd8);   bank_is("R2", 7);
    io_write(8'h40, 8'd2);   bank_is("R1", 7);
    io_write(8'hC0, 8'd1);   bank_is("R1", 7);
  endtask

  task automatic t_mode_bin16_40();
    set_mode(5);             bank_is("R9", 0);
    io_write(8'h40, 8'd15);  bank_is("R2", 15);
    io_write(8'h40, 8'd16);  bank_is("R2", 15);
    io_write(8'hC0, 8'd1);   bank_is("R1", 15);
    io_write(8'h40, 8'd9);   bank_is("R2", 9);
  endtask

  task automatic t_mode_hot8();
    set_mode(2);             bank_is("R9", 0);
    for (int n = 0; n < 8; n++) begin
      io_write(8'h40, 8'h01 << n); bank_is("R3", n);
    end
    io_write(8'h40, 8'h41);  bank_is("R3", 0);
    io_write(8'h40, 8'h42);  bank_is("R3", 1);
    io_write(8'h40, 8'h03);  bank_is("R3", 1);
    io_write(8'h40, 8'h00);  bank_is("R3", 1);
    io_write(8'h40, 8'hC1);  bank_is("R3", 1);
    io_write(8'hFF, 8'h08);  bank_is("R1", 1);
  endtask

  task automatic t_mode_hot7();
    set_mode(3);             bank_is("R9", 0);
    for (int n = 0; n < 7; n++) begin
      io_write(8'h40, 8'h01 << n); bank_is("R4", n);
    end
    io_write(8'h40, 8'h81);  bank_is("R4", 0);
    io_write(8'h40, 8'hC0);  bank_is("R4", 6);
    io_write(8'h40, 8'h80);  bank_is("R4", 6);
    io_write(8'h40, 8'h03);  bank_is("R4", 6);
    io_write(8'h40, 8'h41);  bank_is("R4", 6);
  endtask

  task automatic t_mode_off();
    set_mode(0);
    miss_at("R9", 8'h00);
    io_write(8'h40, 8'h02);
    io_write(8'hC0, 8'd5);
    io_write(8'hFF, 8'd3);
    set_mode(7);
    miss_at("R1", 8'h00);
    set_mode(4);             bank_is("R1", 0);
  endtask

  task automatic t_pages();
    logic [7:0] d; logic h;
    io_write(8'hC0, 8'd0);
    mem_write(8'h40, 8'h11);
    pages(1'b0, 1, 2);
    miss_at("R6", 8'h40);
    miss_at("R6", 8'h80);
    mem_write(8'h40, 8'h22);
    pages(1'b1, 1, 1);
    mem_read(8'h40, d, h);
    chk("R6", "page 1 byte kept", int'(d), 8'h11);
    chk("R6", "page 1 hit", int'(h), 1);
    miss_at("R6", 8'h80);
    mem_write(8'hC5, 8'h3C);
    mem_read(8'hC5, d, h);
    chk("R6", "page 3 byte", int'(d), 8'h3C);
    pages(1'b1, 0, 3);
  endtask

  task automatic t_resets();
    do_cold();
    miss_at("R8", 8'h00);
    pages(1'b1, 0, 3);
    bank_is("R8", 0);
    io_write(8'hC0, 8'd3);
    do_rst();                bank_is("R8", 3);
    io_write(8'hC0, 8'd5);
    do_rst();                bank_is("R8", 0);
    io_write(8'hC0, 8'd7);
    do_rst();                bank_is("R8", 0);
  endtask

  initial begin
    do_cold();
    t_reset_state();
    t_fill_markers();
    t_isolation();
    t_select_latency();
    t_mode_bin16_c0();
    t_mode_bin8_ff();
    t_mode_bin16_40();
    t_mode_hot8();
    t_mode_hot7();
    t_mode_off();
    t_pages();
    t_resets();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule